// File: doc/BRIEF.md
# Receive Word Aligner with Pattern Hunt and Bit Slip

This block sits behind a deserializer and finds the word boundary in a stream of parallel words. It keeps the two most recent input words, which gives a double-width window, and selects any bit offset from that window through a barrel shifter. Bit 0 of each input word is the earliest serial bit. Bit k of the window is bit k of the older word for k below W, and bit k−W of the newer word above that.

In manual mode, software or a link state machine raises a realign request. Each rising edge of that request starts a hunt. The configured pattern is compared at every candidate offset in parallel, and the lowest offset that matches becomes the new boundary. The lock flag then stays up until the next rising edge of the request. A one-cycle pulse marks every output word whose low PLEN bits equal the pattern.

In slip mode, the fabric moves the boundary one bit per transition of a slip input. In this mode the lock flag and the match pulse are held low. The pattern length is checked during elaboration. A 20-bit interface accepts 7, 10 or 20 bits. A 16-bit interface accepts 8 or 16 bits. Any other width accepts 1 to W bits.

Top module: `word_aligner`

## Requirements
- R1: After reset, aligned_word, locked and pattern_seen are 0 and the offset is 0.
- R2: On every clock edge, aligned_word loads bits [off+W-1:off] of the window formed by the words captured on the two previous edges.
- R3: In manual mode (slip_mode=0), a hunt starts only on a cycle where realign_req is 1 and was 0 on the previous cycle. Holding it high, or holding it low, starts nothing, so an unlocked aligner stays unlocked.
- R4: While hunting, in the first cycle that the pattern matches window bits [k+PLEN-1:k] for some k in 0..W-1, the offset becomes the lowest such k. On that same edge, locked rises and aligned_word already uses offset k.
- R5: Once locked in manual mode, locked and the offset stay unchanged, whatever the data, until the next rising edge of realign_req.
- R6: A rising edge of realign_req in manual mode clears locked on the next edge. locked stays low until a new match is found.
- R7: In manual mode, pattern_seen is 1 for exactly those cycles in which aligned_word[PLEN-1:0] equals the pattern. It is updated in the same edge as aligned_word.
- R8: In slip mode, every change of slip_toggle (0 to 1 or 1 to 0) advances the offset by one, wrapping from W-1 to 0. A held level leaves the offset alone.
- R9: In slip mode, realign_req has no effect. One edge after slip mode is entered, locked and pattern_seen are 0, and any hunt is dropped.
- R10: In manual mode, changes of slip_toggle do not move the offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slip_mode | input | 1 | 1 selects bit-slip operation, 0 selects pattern hunt |
| rx_word | input | W | Deserialized word, bit 0 earliest |
| realign_req | input | 1 | Hunt request, acted on at its rising edge |
| slip_toggle | input | 1 | Each transition moves the boundary by one bit in slip mode |
| aligned_word | output | W | Realigned output word |
| locked | output | 1 | Boundary found in manual mode |
| pattern_seen | output | 1 | Output word carries the pattern in its low bits |

## Verification
The hardest case to reach is a pattern that straddles two input words, which locks the aligner at an offset above W-PLEN. A second hard case is a lock that must choose the lowest of several matching offsets. To reach both, the bench builds its words from a serial bit sequence in which the pattern repeats every W bits at a chosen phase. That phase is moved to values of W-PLEN and above. Random filler bits around the pattern sometimes create earlier spurious matches, which the reference model resolves by taking the lowest offset.

// File: rtl/wa_pkg.sv
package wa_pkg;

   typedef enum logic [1:0] {
      WA_IDLE = 2'd0,
      WA_HUNT = 2'd1,
      WA_LOCK = 2'd2
   } wa_state_e;

   // legal pattern lengths for a given parallel width
   function automatic bit wa_len_ok(input int w, input int l);
      if (w == 20) return (l == 7) || (l == 10) || (l == 20);
      if (w == 16) return (l == 8) || (l == 16);
      return (l >= 1) && (l <= w);
   endfunction

endpackage

// File: rtl/wa_window.sv
module wa_window #(
   parameter int W = 20
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [W-1:0]   rx_word,
   output logic [2*W-2:0] win
);
   logic [W-1:0] cur_q;
   logic [W-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q  <= '0;
         prev_q <= '0;
      end else begin
         cur_q  <= rx_word;
         prev_q <= cur_q;
      end
   end

   // top bit of the newer word can never start or end a selected slice
   assign win = {cur_q[W-2:0], prev_q};
endmodule

// File: rtl/wa_match.sv
module wa_match #(
   parameter int             W    = 20,
   parameter int             PLEN = 10,
   parameter logic [PLEN-1:0] PAT = '0,
   localparam int            OW   = (W > 1) ? $clog2(W) : 1
) (
   input  logic [2*W-2:0] win,
   output logic [W-1:0]   mvec,
   output logic           hit,
   output logic [OW-1:0]  hit_off
);
   genvar k;
   generate
      for (k = 0; k < W; k++) begin : g_cmp
         assign mvec[k] = (win[k +: PLEN] == PAT);
      end
   endgenerate

   // lowest matching offset wins
   always_comb begin
      hit     = 1'b0;
      hit_off = '0;
      for (int i = W - 1; i >= 0; i--) begin
         if (mvec[i]) begin
            hit     = 1'b1;
            hit_off = OW'(i);
         end
      end
   end
endmodule

// File: rtl/wa_ctrl.sv
module wa_ctrl #(
   parameter int  W  = 20,
   localparam int OW = (W > 1) ? $clog2(W) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  slip_mode,
   input  logic                  realign_req,
   input  logic                  slip_toggle,
   input  logic                  hit,
   input  logic [OW-1:0]         hit_off,
   output logic [OW-1:0]         eff_off,
   output wa_pkg::wa_state_e     state
);
   import wa_pkg::*;

   localparam logic [OW-1:0] LAST = OW'(W - 1);

   logic          req_q;
   logic          slip_q;
   logic [OW-1:0] off_q;
   logic          rise;
   logic          flip;
   logic          take;

   assign rise = !slip_mode && realign_req && !req_q;
   assign flip = slip_toggle ^ slip_q;
   assign take = !slip_mode && (state == WA_HUNT) && hit && !rise;

   assign eff_off = take ? hit_off : off_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q  <= 1'b0;
         slip_q <= 1'b0;
         off_q  <= '0;
         state  <= WA_IDLE;
      end else begin
         req_q  <= realign_req;
         slip_q <= slip_toggle;
         if (slip_mode) begin
            state <= WA_IDLE;
            if (flip) off_q <= (off_q == LAST) ? '0 : off_q + OW'(1);
         end else if (rise) begin
            state <= WA_HUNT;
         end else if (take) begin
            state <= WA_LOCK;
            off_q <= hit_off;
         end
      end
   end
endmodule

// File: rtl/word_aligner.sv
module word_aligner #(
   parameter int              W    = 20,
   parameter int              PLEN = 10,
   parameter logic [PLEN-1:0] PAT  = 10'h17C
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         slip_mode,
   input  logic [W-1:0] rx_word,
   input  logic         realign_req,
   input  logic         slip_toggle,
   output logic [W-1:0] aligned_word,
   output logic         locked,
   output logic         pattern_seen
);
   import wa_pkg::*;

   localparam int OW = (W > 1) ? $clog2(W) : 1;

   generate
      if (W < 2) begin : g_bad_w
         $error("word_aligner: W must be at least 2");
      end
      if (!wa_len_ok(W, PLEN)) begin : g_bad_len
         $error("word_aligner: pattern length not legal for this width");
      end
   endgenerate

   logic [2*W-2:0] win;
   logic [W-1:0]   mvec;
   logic           hit;
   logic [OW-1:0]  hit_off;
   logic [OW-1:0]  eff_off;
   wa_state_e      state;

   wa_window #(.W(W)) u_win (
      .clk     (clk),
      .rst_n   (rst_n),
      .rx_word (rx_word),
      .win     (win)
   );

   wa_match #(.W(W), .PLEN(PLEN), .PAT(PAT)) u_match (
      .win     (win),
      .mvec    (mvec),
      .hit     (hit),
      .hit_off (hit_off)
   );

   wa_ctrl #(.W(W)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .slip_mode   (slip_mode),
      .realign_req (realign_req),
      .slip_toggle (slip_toggle),
      .hit         (hit),
      .hit_off     (hit_off),
      .eff_off     (eff_off),
      .state       (state)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         aligned_word <= '0;
         pattern_seen <= 1'b0;
      end else begin
         aligned_word <= win[eff_off +: W];
         pattern_seen <= !slip_mode && mvec[eff_off];
      end
   end

   assign locked = (state == WA_LOCK);
endmodule

// File: rtl/word_aligner_chk.sv
module word_aligner_chk #(
   parameter int              W    = 20,
   parameter int              PLEN = 10,
   parameter logic [PLEN-1:0] PAT  = '0
) (
   input logic            clk,
   input logic            rst_n,
   input logic            slip_mode,
   input logic            realign_req,
   input logic [PLEN-1:0] low_bits,
   input logic            locked,
   input logic            pattern_seen
);
   logic armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   // R6
   drop_on_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !slip_mode && realign_req && !$past(realign_req)) |=> !locked);

   // R5
   lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && locked && !slip_mode && !(realign_req && !$past(realign_req))) |=> locked);

   // R7
   seen_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pattern_seen |-> (low_bits == PAT));

   // R4
   lock_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked) |-> pattern_seen);

   // R9
   slip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && slip_mode && $past(slip_mode)) |-> (!locked && !pattern_seen));
endmodule

bind word_aligner word_aligner_chk #(.W(W), .PLEN(PLEN), .PAT(PAT)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .slip_mode    (slip_mode),
   .realign_req  (realign_req),
   .low_bits     (aligned_word[PLEN-1:0]),
   .locked       (locked),
   .pattern_seen (pattern_seen)
);

// File: tb/word_aligner_test.sv
module word_aligner_test;
   localparam int              W    = 20;
   localparam int              PLEN = 10;
   localparam logic [PLEN-1:0] PAT  = 10'h17C;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         slip_mode = 1'b0;
   logic [W-1:0] rx_word = '0;
   logic         realign_req = 1'b0;
   logic         slip_toggle = 1'b0;
   logic [W-1:0] aligned_word;
   logic         locked;
   logic         pattern_seen;

   always #2 clk = ~clk;

   word_aligner #(.W(W), .PLEN(PLEN), .PAT(PAT)) uut (
      .clk(clk), .rst_n(rst_n), .slip_mode(slip_mode), .rx_word(rx_word),
      .realign_req(realign_req), .slip_toggle(slip_toggle),
      .aligned_word(aligned_word), .locked(locked), .pattern_seen(pattern_seen)
   );

   int    total = 0;
   int    bad   = 0;
   int    ncyc  = 0;
   bit    done  = 0;
   string tg    = "R1";

   // reference state: values expected after the latest edge
   logic [W-1:0] m_cur, m_prev, m_dout;
   logic         m_req, m_slq, m_pdet;
   int           m_off, m_st;   // st: 0 idle, 1 hunting, 2 locked
   longint       wcnt = 0;

   task automatic chk(input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h at cycle %0d", tg, what, act, exp, ncyc);
      end
   endtask

   task automatic check_outputs();
      chk("aligned_word", aligned_word, m_dout);
      chk("locked", W'(locked), W'(m_st == 2));
      chk("pattern_seen", W'(pattern_seen), W'(m_pdet));
   endtask

   function automatic logic [2*W-1:0] mwin();
      return {m_cur, m_prev};
   endfunction

   function automatic bit pat_at(input logic [2*W-1:0] w, input int k);
      return w[k +: PLEN] == PAT;
   endfunction

   task automatic model_step(input logic [W-1:0] d, input logic rq, input logic sl, input logic md);
      logic [2*W-1:0] w;
      int  hk;
      int  eff;
      bit  rise;
      w  = mwin();
      hk = -1;
      for (int k = W - 1; k >= 0; k--) if (pat_at(w, k)) hk = k;
      rise = !md && rq && !m_req;
      eff  = (!md && m_st == 1 && hk >= 0 && !rise) ? hk : m_off;
      m_dout = w[eff +: W];
      m_pdet = !md && pat_at(w, eff);
      if (md) begin
         m_st = 0;
         if (sl != m_slq) m_off = (m_off == W - 1) ? 0 : m_off + 1;
      end else if (rise) begin
         m_st = 1;
      end else if (m_st == 1 && hk >= 0) begin
         m_st  = 2;
         m_off = hk;
      end
      m_prev = m_cur;
      m_cur  = d;
      m_req  = rq;
      m_slq  = sl;
   endtask

   // word from a serial sequence carrying the pattern every W bits at phase ph
   task automatic gen_word(input bit inject, input int ph, output logic [W-1:0] d);
      for (int i = 0; i < W; i++) begin
         longint g;
         int     pos;
         g   = wcnt * W + i;
         pos = int'((g - ph + W) % W);
         if (inject && pos < PLEN) d[i] = PAT[pos];
         else                      d[i] = 1'($urandom % 2);
      end
      wcnt++;
   endtask

   task automatic cyc(input logic [W-1:0] d, input logic rq, input logic sl, input logic md);
      check_outputs();
      model_step(d, rq, sl, md);
      rx_word = d; realign_req = rq; slip_toggle = sl; slip_mode = md;
      @(negedge clk);
      ncyc++;
   endtask

   task automatic run(input int n, input bit inject, input int ph,
                      input logic rq, input logic sl, input logic md);
      logic [W-1:0] d;
      for (int i = 0; i < n; i++) begin
         gen_word(inject, ph, d);
         cyc(d, rq, sl, md);
      end
   endtask

   initial begin
      logic [W-1:0] d;
      logic sl;
      logic rq;
      logic md;
      int   ph;
      void'($urandom(32'd4711));
      m_cur = '0; m_prev = '0; m_dout = '0; m_req = 0; m_slq = 0; m_pdet = 0;
      m_off = 0; m_st = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      tg = "R1"; check_outputs();
      tg = "R2"; run(12, 0, 0, 0, 0, 0);
      tg = "R3"; run(15, 1, 6, 0, 0, 0);
      tg = "R4"; run(6, 1, 6, 1, 0, 0);
      tg = "R5"; run(10, 1, 13, 1, 0, 0);
      run(10, 0, 0, 0, 0, 0);
      tg = "R10"; sl = 0;
      for (int i = 0; i < 10; i++) begin
         sl = ~sl;
         run(2, 1, 6, 0, sl, 0);
      end
      tg = "R6"; run(8, 0, 0, 1, sl, 0);
      tg = "R4"; run(8, 1, 17, 1, sl, 0);
      tg = "R7"; run(10, 1, 17, 0, sl, 0);
      for (int i = 0; i < 6; i++) run(1, i % 2, 17, 0, sl, 0);
      tg = "R9";
      for (int i = 0; i < 10; i++) run(1, 1, 3, i % 2, sl, 1);
      tg = "R8";
      for (int t = 0; t < W + 4; t++) begin
         sl = ~sl;
         run(1, 1, 9, 0, sl, 1);
         run(2, 1, 9, 0, sl, 1);
      end
      tg = "R7";
      rq = 0; md = 0; ph = 0;
      for (int i = 0; i < 3000; i++) begin
         if (i % 100 == 0) ph = int'($urandom % W);
         if ($urandom % 200 == 0) md = ~md;
         if ($urandom % 30 == 0)  rq = ~rq;
         if ($urandom % 8 == 0)   sl = ~sl;
         gen_word(($urandom % 10) < 7, ph, d);
         cyc(d, rq, sl, md);
      end
      check_outputs();
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog run did not finish actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule